// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block turns inbound memory writes into interrupt events. Software programs a 64-bit doorbell address. Any inbound write whose address equals that value is taken as an interrupt message. The 32-bit payload of that write is a vector number. Vectors are grouped into banks of 32. Each bank holds three 32-bit registers:

- an enable word, which gates whether a vector may latch;
- a mask word, which keeps a latched vector off the interrupt line;
- a pending word, which records latched vectors and is cleared by writing 1s to it.

A single level interrupt output is high while any pending vector is unmasked. Software reaches every register through a small register bus. The bus has a write strobe, an address and write data. Read data is combinational from the address.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset, every target, enable, mask and pending register reads 0 and `irq_o` is low.
- R2: The low half of the target address is read and written at offset 0x820. The high half is at 0x824.
- R3: Bank b has three registers at offsets from 0x828 + 12*b: enable at +0, mask at +4 and pending at +8. An offset that maps to none of these reads 0.
- R4: An inbound write whose 64-bit address equals {high, low} and whose data n is below 32*NUM_BANKS sets bit n%32 of bank n/32's pending word on that clock edge, provided the matching enable bit is 1.
- R5: A matching write to a vector whose enable bit is 0 leaves the pending words unchanged.
- R6: An inbound write is ignored in two cases: its address differs from the target in either half, or its data is 32*NUM_BANKS or more.
- R7: A register write to a pending word clears each bit written as 1. Bits written as 0 keep their value. No register write can set a pending bit.
- R8: `irq_o` equals the OR over all banks of (pending AND NOT mask). A masked vector still latches into its pending word.
- R9: A capture and a clear that hit the same pending bit on the same edge leave that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Inbound memory write present |
| in_addr_i | input | 64 | Inbound write address |
| in_data_i | input | 32 | Inbound write data (vector number) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default values: eight banks and a 12-byte stride. This places the last pending word at 0x884, so the top register of the map is exercised. It also puts the range limit at 256, so vectors 255 and 256 sit on each side of the boundary. A 12-bit offset leaves room for unmapped probes beyond the map. With eight banks, random vectors spread across enough banks to catch index or stride errors in the bank decode.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned VEC_PER_BANK = 32;
  localparam int unsigned REG_W        = 32;
  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/msi_target_match.sv
module msi_target_match
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned NUM_VEC  = NUM_BANKS * VEC_PER_BANK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  word_t             wdata_i,
  input  logic              in_valid_i,
  input  logic [63:0]       in_addr_i,
  input  logic [31:0]       in_data_i,
  output word_t             tgt_lo_o,
  output word_t             tgt_hi_o,
  output logic              hit_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [4:0]        bit_o
);
  word_t tgt_lo_q, tgt_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_lo_q <= '0;
      tgt_hi_q <= '0;
    end else begin
      if (we_lo_i) tgt_lo_q <= wdata_i;
      if (we_hi_i) tgt_hi_q <= wdata_i;
    end
  end

  logic addr_eq, in_range;
  assign addr_eq  = (in_addr_i == {tgt_hi_q, tgt_lo_q});
  assign in_range = (in_data_i < 32'(NUM_VEC));
  assign hit_o    = in_valid_i && addr_eq && in_range;

  if (NUM_BANKS > 1) begin : g_multi
    assign bank_o = in_data_i[5 +: BANK_W];
  end else begin : g_single
    assign bank_o = 1'b0;
  end
  assign bit_o    = in_data_i[4:0];
  assign tgt_lo_o = tgt_lo_q;
  assign tgt_hi_o = tgt_hi_q;

  // R6: a vector at or beyond the limit never produces a hit
  p_no_oor_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_data_i >= 32'(NUM_VEC)) |-> !hit_o);
endmodule

// File: rtl/msi_bank.sv
module msi_bank
  import msi_cap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_en_i,
  input  logic  we_mask_i,
  input  logic  we_clr_i,
  input  word_t wdata_i,
  input  word_t cap_i,
  output word_t en_o,
  output word_t mask_o,
  output word_t pend_o,
  output logic  irq_o
);
  word_t en_q, mask_q, pend_q;
  word_t set_v, clr_v;

  assign set_v = cap_i & en_q;
  assign clr_v = we_clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (we_en_i)   en_q   <= wdata_i;
      if (we_mask_i) mask_q <= wdata_i;
      pend_q <= (pend_q & ~clr_v) | set_v;  // set after clear: capture wins
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ~mask_q);

  p_set_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));
  p_clear_only_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_q) & ~pend_q & ~$past(clr_v)) == '0));
  p_capture_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(set_v & clr_v) & ~pend_q) == '0));
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned REG_AW      = 12,
  parameter int unsigned TGT_LO_OFF  = 'h820,
  parameter int unsigned TGT_HI_OFF  = 'h824,
  parameter int unsigned BANK0_OFF   = 'h828,
  parameter int unsigned BANK_STRIDE = 12,
  localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [63:0]       in_addr_i,
  input  logic [31:0]       in_data_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic              sel_lo, sel_hi, hit;
  logic [BANK_W-1:0] hit_bank;
  logic [4:0]        hit_bit;
  word_t             tgt_lo, tgt_hi;

  assign sel_lo = (reg_addr_i == REG_AW'(TGT_LO_OFF));
  assign sel_hi = (reg_addr_i == REG_AW'(TGT_HI_OFF));

  msi_target_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_lo_i    (reg_we_i && sel_lo),
    .we_hi_i    (reg_we_i && sel_hi),
    .wdata_i    (reg_wdata_i),
    .in_valid_i (in_valid_i),
    .in_addr_i  (in_addr_i),
    .in_data_i  (in_data_i),
    .tgt_lo_o   (tgt_lo),
    .tgt_hi_o   (tgt_hi),
    .hit_o      (hit),
    .bank_o     (hit_bank),
    .bit_o      (hit_bit)
  );

  word_t                en_a   [NUM_BANKS];
  word_t                mask_a [NUM_BANKS];
  word_t                pend_a [NUM_BANKS];
  logic [NUM_BANKS-1:0] sel_en, sel_mask, sel_pend, bank_irq;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE = BANK0_OFF + BANK_STRIDE * b;
    word_t cap;
    assign sel_en[b]   = (reg_addr_i == REG_AW'(BASE));
    assign sel_mask[b] = (reg_addr_i == REG_AW'(BASE + 4));
    assign sel_pend[b] = (reg_addr_i == REG_AW'(BASE + 8));
    assign cap = (hit && hit_bank == BANK_W'(b)) ? (word_t'(1) << hit_bit) : '0;

    msi_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_en_i   (reg_we_i && sel_en[b]),
      .we_mask_i (reg_we_i && sel_mask[b]),
      .we_clr_i  (reg_we_i && sel_pend[b]),
      .wdata_i   (reg_wdata_i),
      .cap_i     (cap),
      .en_o      (en_a[b]),
      .mask_o    (mask_a[b]),
      .pend_o    (pend_a[b]),
      .irq_o     (bank_irq[b])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_lo) reg_rdata_o = tgt_lo;
    if (sel_hi) reg_rdata_o = tgt_hi;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_en[b])   reg_rdata_o = en_a[b];
      if (sel_mask[b]) reg_rdata_o = mask_a[b];
      if (sel_pend[b]) reg_rdata_o = pend_a[b];
    end
  end

  assign irq_o = |bank_irq;

  logic all_masked, pend_change;
  always_comb begin
    all_masked  = 1'b1;
    pend_change = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) all_masked = all_masked && (&mask_a[b]);
  end

  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_masked |-> !irq_o);
  p_idle_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(in_valid_i) && !$past(reg_we_i)) |-> ($stable(pend_a[0]) && $stable(irq_o)));
  p_single_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_lo, sel_hi, sel_en, sel_mask, sel_pend}));
endmodule

// File: tb/msi_capture_ctrl_tb.sv
module msi_capture_ctrl_tb_top;
  localparam int NB = 8;
  localparam int NV = NB * 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #5 clk = ~clk;

  msi_capture_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_addr_i(in_addr),
    .in_data_i(in_data), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  int total = 0, bad = 0;
  logic [31:0] m_lo, m_hi;
  logic [31:0] m_en [NB];
  logic [31:0] m_mk [NB];
  logic [31:0] m_pd [NB];

  function automatic logic [11:0] en_off(int b);   return 12'(32'h828 + 12*b); endfunction
  function automatic logic [11:0] mk_off(int b);   return 12'(32'h828 + 12*b + 4); endfunction
  function automatic logic [11:0] pd_off(int b);   return 12'(32'h828 + 12*b + 8); endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int b = 0; b < NB; b++) r = r | (|(m_pd[b] & ~m_mk[b]));
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus on both buses, model updated as the design should
  task automatic step(logic we, logic [11:0] ra, logic [31:0] wd,
                      logic v, logic [63:0] a, logic [31:0] d);
    logic [31:0] setv [NB];
    for (int b = 0; b < NB; b++) setv[b] = '0;
    if (v && a == {m_hi, m_lo} && d < NV)
      setv[d/32] = (32'd1 << (d % 32)) & m_en[d/32];
    @(negedge clk);
    reg_we = we; reg_addr = ra; reg_wdata = wd;
    in_valid = v; in_addr = a; in_data = d;
    @(negedge clk);
    reg_we = 1'b0; in_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      logic [31:0] clr;
      clr = (we && ra == pd_off(b)) ? wd : 32'd0;
      if (we && ra == en_off(b)) m_en[b] = wd;
      if (we && ra == mk_off(b)) m_mk[b] = wd;
      m_pd[b] = (m_pd[b] & ~clr) | setv[b];
    end
    if (we && ra == 12'h820) m_lo = wd;
    if (we && ra == 12'h824) m_hi = wd;
  endtask

  task automatic rd(string tag, logic [11:0] ra, logic [31:0] exp);
    reg_addr = ra;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(logic [11:0] ra, logic [31:0] wd);
    step(1'b1, ra, wd, 1'b0, '0, '0);
  endtask

  task automatic msi(logic [63:0] a, logic [31:0] d);
    step(1'b0, 12'h0, '0, 1'b1, a, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] tgt;
    logic [31:0] s;
    s = $urandom(32'h1c0ffee);
    m_lo = '0; m_hi = '0;
    for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_mk[b] = '0; m_pd[b] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1 lo", 12'h820, 0);
    rd("R1 hi", 12'h824, 0);
    for (int b = 0; b < NB; b++) begin
      rd("R1 en", en_off(b), 0); rd("R1 mask", mk_off(b), 0); rd("R1 pend", pd_off(b), 0);
    end
    chk("R1 irq", 32'(irq), 0);

    // R2 target registers
    tgt = 64'h0000_00AB_FEED_0040;
    wr(12'h820, tgt[31:0]);
    wr(12'h824, tgt[63:32]);
    rd("R2 lo", 12'h820, tgt[31:0]);
    rd("R2 hi", 12'h824, tgt[63:32]);

    // R3 register map and unmapped offsets
    wr(en_off(7), 32'hA5A5_0001);
    wr(mk_off(3), 32'h0F0F_0000);
    rd("R3 en7", en_off(7), 32'hA5A5_0001);
    rd("R3 mk3", mk_off(3), 32'h0F0F_0000);
    rd("R3 unmapped 0x888", 12'h888, 0);
    rd("R3 unmapped 0x81c", 12'h81C, 0);
    rd("R3 unmapped 0x82a", 12'h82A, 0);

    // R5 disabled vector does not latch
    msi(tgt, 32'd7 * 32 + 1);
    rd("R5 pend7", pd_off(7), 0);
    chk("R5 irq", 32'(irq), 0);

    // R4 enabled vector latches; vector 255 top boundary
    msi(tgt, 32'd7 * 32);
    rd("R4 pend7 bit0", pd_off(7), 32'h1);
    chk("R4/R8 irq", 32'(irq), 1);
    wr(en_off(7), 32'hFFFF_FFFF);
    msi(tgt, 32'd255);
    rd("R4 vector 255", pd_off(7), 32'h8000_0001);

    // R6 out of range and mismatches
    wr(en_off(0), 32'hFFFF_FFFF);
    msi(tgt, 32'd256);
    msi(tgt ^ 64'h1, 32'd3);
    msi(tgt ^ 64'h1_0000_0000, 32'd4);
    rd("R6 pend0", pd_off(0), 0);
    rd("R6 pend7", pd_off(7), 32'h8000_0001);

    // R7 W1C
    wr(pd_off(7), 32'h0000_0001);
    rd("R7 clear bit0", pd_off(7), 32'h8000_0000);
    wr(pd_off(7), 32'h7FFF_FFFF);
    rd("R7 zeros keep", pd_off(7), 32'h8000_0000);
    wr(pd_off(0), 32'hFFFF_FFFF);
    rd("R7 no set by write", pd_off(0), 0);

    // R8 masked still latches, no irq
    wr(pd_off(7), 32'hFFFF_FFFF);
    wr(en_off(3), 32'hFFFF_FFFF);
    msi(tgt, 32'd3 * 32 + 16);
    rd("R8 masked latches", pd_off(3), 32'h0001_0000);
    chk("R8 masked irq low", 32'(irq), 0);
    wr(mk_off(3), 32'h0);
    chk("R8 unmask irq", 32'(irq), 1);

    // R9 capture beats clear
    step(1'b1, pd_off(3), 32'h0001_0000, 1'b1, tgt, 32'd3 * 32 + 16);
    rd("R9 capture wins", pd_off(3), 32'h0001_0000);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op, b;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      b  = $urandom_range(0, NB - 1);
      d  = $urandom_range(0, NV + 40);
      case (op)
        0, 1, 2: msi(tgt, d);
        3:       msi(tgt ^ (64'd1 << $urandom_range(0, 63)), d);
        4:       wr(en_off(b), $urandom());
        5:       wr(mk_off(b), $urandom());
        6, 7:    wr(pd_off(b), $urandom());
        default: step(1'b1, pd_off(d / 32 % NB), $urandom(), 1'b1, tgt, d);
      endcase
      chk("R8 irq random", 32'(irq), 32'(exp_irq()));
      rd("R4/R7 pend random", pd_off(b), m_pd[b]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule